// File: doc/BRIEF.md
# Synchronous Bus Master Sequencer

This block sits between a local client and a shared synchronous bus. It takes one read or write request at a time and carries it out as a fixed three-cycle transaction. The bus has separate address, data-out and data-in buses, plus address-enable, read and write control lines. There is no acknowledge from the slave. The slave must keep to the schedule: for a read it returns data one cycle after it sees the read command, and for a write it latches the data during the last cycle.

The client raises a request strobe together with a direction bit, an address and write data. The block latches all of them when it accepts the request. It then shows busy until the transaction ends, and gives a one-cycle done pulse. For a read, the returned word is valid on the client side while done is high.

Top module: `bus_master_seq`

## Requirements
- R1: While reset is held and after it is released with no request, busy, done, address enable, read and write are all low, and the bus address and bus data-out are zero.
- R2: A request is accepted only in a cycle where busy is low. A strobe seen while busy is high is ignored, so the address and direction of the transaction in progress do not change.
- R3: In the first cycle after acceptance (the address cycle), the bus address carries the accepted address and address enable is high. Both are held unchanged through the third cycle.
- R4: For a read (direction bit 0), the read line is high in the second and third cycles only, and the write line stays low.
- R5: For a read, the word on the bus data-in at the end of the third cycle appears on the client read-data output in the following cycle, while done is high.
- R6: For a write (direction bit 1), the bus data-out carries the accepted write data and the write line is high in the second and third cycles only. The read line stays low, and data-out is zero at all other times.
- R7: Read and write are never high in the same cycle. Whenever busy is low, address enable, read and write are all low.
- R8: Busy is high for exactly the three transaction cycles. Done is a single-cycle pulse in the cycle right after the third cycle, and busy is low in that cycle.
- R9: A request present in the done cycle is accepted, so its address cycle follows immediately. Back-to-back transactions therefore take four cycles each.
- R10: Changing the client address, write data or direction after acceptance has no effect on the bus until the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req | input | 1 | Client request strobe |
| cli_wr | input | 1 | Direction: 1 write, 0 read |
| cli_addr | input | ADDR_W | Client address |
| cli_wdata | input | DATA_W | Client write data |
| cli_busy | output | 1 | Transaction in progress |
| cli_done | output | 1 | One-cycle completion pulse |
| cli_rdata | output | DATA_W | Read result, valid with done |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_ae | output | 1 | Bus address enable |
| bus_rd | output | 1 | Bus read command |
| bus_wr | output | 1 | Bus write command |
| bus_dout | output | DATA_W | Bus data lines toward the slave |
| bus_din | input | DATA_W | Bus data lines from the slave |

## Verification
The hardest case to reach from the ports is a request strobe that stays high through a whole transaction, with its address and direction changing, and then gets accepted in the done cycle. Only that case separates "ignored while busy" from "accepted back-to-back". The bench holds the strobe high across the transaction and changes the client fields mid-flight. It checks that the bus fields stay frozen, and then that the new request starts its address cycle right after done. Every transaction in the vector walk also scrambles the client inputs after acceptance, and a small registered memory slave answers on the fixed schedule.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    function automatic logic in_cmd_window(input phase_e p);
        return (p == PH_CMD) || (p == PH_DATA);
    endfunction

endpackage

// File: rtl/bms_seq.sv
module bms_seq
    import bms_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   req_wr,
    output phase_e phase_q_o,
    output phase_e phase_nx_o,
    output logic   wr_q_o,
    output logic   wr_nx_o,
    output logic   accept_o,
    output logic   busy_o,
    output logic   done_o
);

    typedef struct packed {
        phase_e phase;
        logic   wr;
        logic   done;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = req && (s_q.phase == PH_IDLE);
        case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.phase = PH_ADDR;
                    s_d.wr    = req_wr;
                end
            end
            PH_ADDR: s_d.phase = PH_CMD;
            PH_CMD:  s_d.phase = PH_DATA;
            PH_DATA: begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.wr    <= 1'b0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q_o  = s_q.phase;
    assign phase_nx_o = s_d.phase;
    assign wr_q_o     = s_q.wr;
    assign wr_nx_o    = s_d.wr;
    assign accept_o   = accept;
    assign busy_o     = (s_q.phase != PH_IDLE);
    assign done_o     = s_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R8
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req)) else $error("busy without request"); // R2
    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(wr_q_o)) else $error("direction changed"); // R10

endmodule

// File: rtl/bms_bus_drv.sv
module bms_bus_drv
    import bms_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cli_addr,
    input  logic [DATA_W-1:0] cli_wdata,
    input  phase_e            phase_nx,
    input  logic              wr_nx,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_ae,
    output logic              bus_rd,
    output logic              bus_wr
);

    localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;
    localparam logic [DATA_W-1:0] DATA_ZERO = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] wbuf;
        logic              ae;
        logic              rd;
        logic              wr;
    } drv_t;

    drv_t d_d, d_q;
    logic active_nx;
    logic cmd_nx;

    always_comb begin
        d_d       = d_q;
        active_nx = (phase_nx != PH_IDLE);
        cmd_nx    = in_cmd_window(phase_nx);
        if (accept) begin
            d_d.addr = cli_addr;
            d_d.wbuf = cli_wdata;
        end else if (!active_nx) begin
            d_d.addr = ADDR_ZERO;
        end
        d_d.ae   = active_nx;
        d_d.rd   = cmd_nx && !wr_nx;
        d_d.wr   = cmd_nx && wr_nx;
        d_d.dout = (cmd_nx && wr_nx) ? d_q.wbuf : DATA_ZERO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign bus_addr = d_q.addr;
    assign bus_dout = d_q.dout;
    assign bus_ae   = d_q.ae;
    assign bus_rd   = d_q.rd;
    assign bus_wr   = d_q.wr;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)) else $error("read and write together"); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ae && $past(bus_ae)) |-> $stable(bus_addr)) else $error("address moved"); // R3
    AST_RD_AFTER_AE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> (bus_ae && $past(bus_ae) && !$past(bus_rd))) else $error("read early"); // R4
    AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> $stable(bus_dout)) else $error("write data moved"); // R6

endmodule

// File: rtl/bms_rd_cap.sv
module bms_rd_cap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (capture) begin
            c_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rdata = c_q.word;

    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture) |-> (rdata == $past(din))) else $error("capture lost"); // R5

endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
    import bms_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cli_req,
    input  logic              cli_wr,
    input  logic [ADDR_W-1:0] cli_addr,
    input  logic [DATA_W-1:0] cli_wdata,
    output logic              cli_busy,
    output logic              cli_done,
    output logic [DATA_W-1:0] cli_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ae,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);

    phase_e phase_q;
    phase_e phase_nx;
    logic   wr_q;
    logic   wr_nx;
    logic   accept;
    logic   capture;

    bms_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cli_req),
        .req_wr    (cli_wr),
        .phase_q_o (phase_q),
        .phase_nx_o(phase_nx),
        .wr_q_o    (wr_q),
        .wr_nx_o   (wr_nx),
        .accept_o  (accept),
        .busy_o    (cli_busy),
        .done_o    (cli_done)
    );

    bms_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cli_addr (cli_addr),
        .cli_wdata(cli_wdata),
        .phase_nx (phase_nx),
        .wr_nx    (wr_nx),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .bus_ae   (bus_ae),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr)
    );

    assign capture = (phase_q == PH_DATA) && !wr_q;

    bms_rd_cap #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .din    (bus_din),
        .rdata  (cli_rdata)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cli_busy |-> (!bus_ae && !bus_rd && !bus_wr)) else $error("control active while idle"); // R7
    AST_DONE_ENDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        cli_done |-> ($past(bus_ae) && !cli_busy)) else $error("done misplaced"); // R8
    AST_BUSY_WITH_AE: assert property (@(posedge clk) disable iff (!rst_n)
        cli_busy == bus_ae) else $error("busy and address enable disagree"); // R3

endmodule

// File: tb/sim_bus_master_seq.sv
`timescale 1ns/1ps
module sim_bus_master_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NV = 8;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0003, 16'hBEEF},
        '{1'b0, 16'h0003, 16'h0000},
        '{1'b0, 16'h0007, 16'h0000},
        '{1'b1, 16'h000C, 16'h1234},
        '{1'b1, 16'h0100, 16'hFFFF},
        '{1'b0, 16'h000C, 16'h0000},
        '{1'b0, 16'h0100, 16'h0000},
        '{1'b1, 16'h0003, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cli_req = 1'b0;
    logic cli_wr = 1'b0;
    logic [AW-1:0] cli_addr = '0;
    logic [DW-1:0] cli_wdata = '0;
    logic cli_busy, cli_done;
    logic [DW-1:0] cli_rdata;
    logic [AW-1:0] bus_addr;
    logic bus_ae, bus_rd, bus_wr;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] slave_mem [16];
    logic [DW-1:0] slave_q = '0;
    logic [DW-1:0] ref_mem [16];

    always #4 clk = ~clk;

    bus_master_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cli_req(cli_req), .cli_wr(cli_wr),
        .cli_addr(cli_addr), .cli_wdata(cli_wdata), .cli_busy(cli_busy),
        .cli_done(cli_done), .cli_rdata(cli_rdata), .bus_addr(bus_addr),
        .bus_ae(bus_ae), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    // registered slave: data one cycle after read, latch on write
    always @(posedge clk) begin
        if (bus_wr) slave_mem[bus_addr[3:0]] <= bus_dout;
        if (bus_rd) slave_q <= slave_mem[bus_addr[3:0]];
    end
    assign bus_din = slave_q;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctrl_chk(input string tag, input logic ae, input logic rd, input logic wr,
                            input logic busy, input logic done);
        chk(tag, {27'd0, bus_ae, bus_rd, bus_wr, cli_busy, cli_done},
                 {27'd0, ae, rd, wr, busy, done});
    endtask

    // Called at a falling edge; leaves at the falling edge of the done cycle.
    task automatic run_txn(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] w);
        logic [DW-1:0] exp_rd;
        exp_rd = ref_mem[a[3:0]];
        cli_req = 1'b1; cli_wr = we; cli_addr = a; cli_wdata = w;
        @(negedge clk);
        ctrl_chk("R3 addr cycle ctrl", 1, 0, 0, 1, 0);
        chk("R3 addr cycle address", {16'd0, bus_addr}, {16'd0, a});
        chk("R6 dout zero in addr cycle", {16'd0, bus_dout}, 32'd0);
        cli_req = 1'b0; cli_wr = ~we; cli_addr = ~a; cli_wdata = ~w;  // R10 scramble
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            ctrl_chk(we ? "R6 write cmd ctrl" : "R4 read cmd ctrl", 1, !we, we, 1, 0);
            chk("R10 address held", {16'd0, bus_addr}, {16'd0, a});
            chk("R6 dout", {16'd0, bus_dout}, {16'd0, (we ? w : '0)});
        end
        @(negedge clk);
        ctrl_chk("R8 done cycle ctrl", 0, 0, 0, 0, 1);
        if (!we) chk("R5 read data", {16'd0, cli_rdata}, {16'd0, exp_rd});
        else ref_mem[a[3:0]] = w;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            slave_mem[i] = 16'h5A00 | 16'(i);
            ref_mem[i]   = 16'h5A00 | 16'(i);
        end
        repeat (3) @(negedge clk);
        ctrl_chk("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctrl_chk("R1 after reset", 0, 0, 0, 0, 0);
        chk("R1 bus addr zero", {16'd0, bus_addr}, 32'd0);
        chk("R1 dout zero", {16'd0, bus_dout}, 32'd0);

        // vector walk, back-to-back (R9: request in done cycle)
        for (int v = 0; v < NV; v++) begin
            run_txn(VEC[v].we, VEC[v].addr, VEC[v].wdata);
        end
        cli_req = 1'b0;
        @(negedge clk);
        ctrl_chk("R8 idle after done", 0, 0, 0, 0, 0);

        // R2/R9: strobe held high through a read with changing fields
        cli_req = 1'b1; cli_wr = 1'b0; cli_addr = 16'h0005; cli_wdata = 16'h0000;
        @(negedge clk);
        ctrl_chk("R2 accepted read", 1, 0, 0, 1, 0);
        cli_wr = 1'b1; cli_addr = 16'h0009; cli_wdata = 16'hC0DE;
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            ctrl_chk("R2 ignored while busy", 1, 1, 0, 1, 0);
            chk("R2 address unchanged", {16'd0, bus_addr}, 32'h0005);
        end
        @(negedge clk);
        ctrl_chk("R2 done", 0, 0, 0, 0, 1);
        chk("R5 held-strobe read", {16'd0, cli_rdata}, {16'd0, ref_mem[5]});
        @(negedge clk);
        ctrl_chk("R9 next starts at once", 1, 0, 0, 1, 0);
        chk("R9 new address", {16'd0, bus_addr}, 32'h0009);
        cli_req = 1'b0;
        @(negedge clk);
        ctrl_chk("R6 held-strobe write", 1, 0, 1, 1, 0);
        chk("R6 held-strobe dout", {16'd0, bus_dout}, 32'hC0DE);
        repeat (2) @(negedge clk);
        ctrl_chk("R8 second done", 0, 0, 0, 0, 1);
        ref_mem[9] = 16'hC0DE;
        run_txn(1'b0, 16'h0009, 16'h0000);
        cli_req = 1'b0;
        @(negedge clk);
        ctrl_chk("R7 idle quiet", 0, 0, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule